// File: doc/BRIEF.md
# Virtual Interrupt Slot

This block is a single slot that holds one virtual interrupt for a guest CPU interface. Software loads the slot with a virtual interrupt number, a two-bit state, a hardware-link flag and a physical interrupt number. The guest side has two strobes. An acknowledge strobe returns the held number and marks the interrupt active. A deactivate strobe, which carries an interrupt number, retires the interrupt.

When the hardware-link flag is set, the slot stands for a physical interrupt that is still active at the distributor. A guest deactivation of such a slot produces a one-cycle request to the distributor that carries the stored physical number. A linked slot may be pending or active, never both, and software writes that ask for both are refused.

The state encoding is bit 0 = pending and bit 1 = active: 2'b00 inactive, 2'b01 pending, 2'b10 active, 2'b11 pending+active.

Top module: `virq_slot`

## Requirements
- R1: After reset the slot reads back all zeros (inactive, unlinked), `slot_empty` is 1, and `phys_deact_vld` and `wr_err` are 0.
- R2: An accepted software write loads the virtual number, state, link flag and physical number. These are visible on the read-back ports after the next clock edge, and `slot_empty` is 1 exactly when the state reads 2'b00.
- R3: A guest acknowledge of a pending-only slot (2'b01) returns the virtual number on `gst_ack_id` in the same cycle, and the state becomes active (2'b10) after the edge.
- R4: A guest acknowledge of an unlinked pending+active slot (2'b11) returns the virtual number and leaves the state active only (2'b10).
- R5: A guest acknowledge of an inactive or active-only slot returns the spurious number 1023 and leaves the state unchanged.
- R6: The pending bit stays set until the slot is acknowledged or rewritten. Idle cycles and deactivate strobes do not clear it.
- R7: A deactivate strobe whose number matches the stored virtual number clears the active bit and keeps the pending bit (2'b10 to 2'b00, 2'b11 to 2'b01). A strobe with any other number changes nothing.
- R8: A matching deactivation of an active, linked slot raises `phys_deact_vld` for exactly one cycle after the edge, with `phys_deact_pid` equal to the stored physical number. An unlinked slot never raises it.
- R9: A software write of state 2'b11 with the link flag set is rejected. The slot keeps its previous contents, and `wr_err` is 1 for the one cycle after the edge.
- R10: A software write, accepted or rejected, takes priority over guest strobes in the same cycle. The guest strobes are then ignored: `gst_ack_id` shows 1023 and no physical request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_vid | input | VID_W | Virtual interrupt number to load |
| sw_wr_state | input | 2 | State to load (bit0 pending, bit1 active) |
| sw_wr_link | input | 1 | Hardware-link flag to load |
| sw_wr_pid | input | PID_W | Physical interrupt number to load |
| rd_vid | output | VID_W | Stored virtual number |
| rd_state | output | 2 | Stored state |
| rd_link | output | 1 | Stored link flag |
| rd_pid | output | PID_W | Stored physical number |
| slot_empty | output | 1 | High when the state is inactive |
| wr_err | output | 1 | One-cycle flag for a rejected write |
| gst_ack | input | 1 | Guest acknowledge strobe |
| gst_ack_id | output | VID_W | Number returned to the acknowledge (same cycle) |
| gst_deact | input | 1 | Guest deactivate strobe |
| gst_deact_id | input | VID_W | Number carried by the deactivate |
| phys_deact_vld | output | 1 | Deactivate request to the distributor |
| phys_deact_pid | output | PID_W | Physical number of the request |

## Verification
The hardest case to reach is a collision: a software write arriving in the same cycle as a guest strobe on a linked, active slot. Only that case shows whether the write truly masks the physical request. The bench first walks the slot to linked-active through a write and an acknowledge. It then asserts the write and a matching deactivate together, and checks that no request appears. The refused pending+active write is handled the same way. A linked slot is loaded first, so the check can show that its old contents survive.

// File: rtl/virq_pkg.sv
package virq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_PEND = 2'b01,
        ST_ACT  = 2'b10,
        ST_BOTH = 2'b11
    } vstate_e;
endpackage

// File: rtl/virq_write_check.sv
module virq_write_check
    import virq_pkg::*;
(
    input  logic    wr_en_i,
    input  vstate_e wr_st_i,
    input  logic    wr_link_i,
    output logic    accept_o,
    output logic    reject_o
);
    // A linked slot may not be both pending and active.
    always_comb begin
        reject_o = wr_en_i & wr_link_i & (wr_st_i == ST_BOTH);
        accept_o = wr_en_i & ~reject_o;
    end
endmodule

// File: rtl/virq_guest_ops.sv
module virq_guest_ops
    import virq_pkg::*;
#(
    parameter int VID_W       = 10,
    parameter int SPURIOUS_ID = 1023
) (
    input  vstate_e          st_i,
    input  logic [VID_W-1:0] vid_i,
    input  logic             ack_i,
    input  logic             deact_i,
    input  logic [VID_W-1:0] deact_id_i,
    output vstate_e          st_o,
    output logic [VID_W-1:0] ack_id_o,
    output logic             deact_hit_o
);
    localparam logic [VID_W-1:0] SPUR = VID_W'(SPURIOUS_ID);

    logic ack_hit;
    logic pend_n;
    logic act_n;

    always_comb begin
        ack_hit     = ack_i & st_i[0];
        deact_hit_o = deact_i & st_i[1] & (deact_id_i == vid_i);
        pend_n      = st_i[0] & ~ack_hit;
        // an acknowledge in the same cycle leaves the interrupt active
        act_n       = (st_i[1] & ~deact_hit_o) | ack_hit;
        st_o        = vstate_e'({act_n, pend_n});
        ack_id_o    = ack_hit ? vid_i : SPUR;
    end
endmodule

// File: rtl/virq_slot.sv
module virq_slot
    import virq_pkg::*;
#(
    parameter int VID_W       = 10,
    parameter int PID_W       = 10,
    parameter int SPURIOUS_ID = 1023
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_wr_en,
    input  logic [VID_W-1:0] sw_wr_vid,
    input  logic [1:0]       sw_wr_state,
    input  logic             sw_wr_link,
    input  logic [PID_W-1:0] sw_wr_pid,
    output logic [VID_W-1:0] rd_vid,
    output logic [1:0]       rd_state,
    output logic             rd_link,
    output logic [PID_W-1:0] rd_pid,
    output logic             slot_empty,
    output logic             wr_err,
    input  logic             gst_ack,
    output logic [VID_W-1:0] gst_ack_id,
    input  logic             gst_deact,
    input  logic [VID_W-1:0] gst_deact_id,
    output logic             phys_deact_vld,
    output logic [PID_W-1:0] phys_deact_pid
);
    localparam logic [VID_W-1:0] SPUR = VID_W'(SPURIOUS_ID);

    typedef struct packed {
        logic [VID_W-1:0] vid;
        logic [PID_W-1:0] pid;
        logic             link;
        vstate_e          st;
        logic             err;
        logic             pvld;
        logic [PID_W-1:0] ppid;
    } slot_t;

    slot_t   slot_d, slot_q;
    vstate_e wr_st;
    vstate_e g_st;
    logic [VID_W-1:0] g_ack_id;
    logic    g_deact_hit;
    logic    wr_accept;
    logic    wr_reject;

    assign wr_st = vstate_e'(sw_wr_state);

    virq_write_check u_wchk (
        .wr_en_i  (sw_wr_en),
        .wr_st_i  (wr_st),
        .wr_link_i(sw_wr_link),
        .accept_o (wr_accept),
        .reject_o (wr_reject)
    );

    virq_guest_ops #(
        .VID_W      (VID_W),
        .SPURIOUS_ID(SPURIOUS_ID)
    ) u_gops (
        .st_i       (slot_q.st),
        .vid_i      (slot_q.vid),
        .ack_i      (gst_ack),
        .deact_i    (gst_deact),
        .deact_id_i (gst_deact_id),
        .st_o       (g_st),
        .ack_id_o   (g_ack_id),
        .deact_hit_o(g_deact_hit)
    );

    always_comb begin
        slot_d      = slot_q;
        slot_d.err  = 1'b0;
        slot_d.pvld = 1'b0;
        if (sw_wr_en) begin
            if (wr_accept) begin
                slot_d.vid  = sw_wr_vid;
                slot_d.pid  = sw_wr_pid;
                slot_d.link = sw_wr_link;
                slot_d.st   = wr_st;
            end
            if (wr_reject) begin
                slot_d.err = 1'b1;
            end
        end else begin
            slot_d.st = g_st;
            if (g_deact_hit && slot_q.link) begin
                slot_d.pvld = 1'b1;
                slot_d.ppid = slot_q.pid;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign rd_vid         = slot_q.vid;
    assign rd_state       = slot_q.st;
    assign rd_link        = slot_q.link;
    assign rd_pid         = slot_q.pid;
    assign slot_empty     = (slot_q.st == ST_IDLE);
    assign wr_err         = slot_q.err;
    assign gst_ack_id     = sw_wr_en ? SPUR : g_ack_id;
    assign phys_deact_vld = slot_q.pvld;
    assign phys_deact_pid = slot_q.ppid;

    AST_LINK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_link |-> (rd_state != 2'b11)); // R9
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(sw_wr_en && sw_wr_link && sw_wr_state == 2'b11)); // R9
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        phys_deact_vld |=> !phys_deact_vld); // R8
    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        phys_deact_vld |-> $past(rd_link && rd_state[1] && gst_deact && !sw_wr_en)); // R8
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr_en && !gst_ack && rd_state[0]) |=> rd_state[0]); // R6
    AST_SPUR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (gst_ack && !rd_state[0]) |-> (gst_ack_id == SPUR)); // R5
endmodule

// File: tb/sim_virq_slot.sv
module sim_virq_slot;
    localparam int VW = 10;
    localparam int PW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_wr_en = 1'b0;
    logic [VW-1:0] sw_wr_vid = '0;
    logic [1:0]    sw_wr_state = '0;
    logic          sw_wr_link = 1'b0;
    logic [PW-1:0] sw_wr_pid = '0;
    logic [VW-1:0] rd_vid;
    logic [1:0]    rd_state;
    logic          rd_link;
    logic [PW-1:0] rd_pid;
    logic          slot_empty;
    logic          wr_err;
    logic          gst_ack = 1'b0;
    logic [VW-1:0] gst_ack_id;
    logic          gst_deact = 1'b0;
    logic [VW-1:0] gst_deact_id = '0;
    logic          phys_deact_vld;
    logic [PW-1:0] phys_deact_pid;

    int n_chk = 0;
    int n_bad = 0;
    int last_ack = 0;

    always #2 clk = ~clk;

    virq_slot u0 (.*);

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle of stimulus; last_ack captures gst_ack_id before the edge.
    task automatic step(input logic we, input int wvid, input int wst, input logic wlink,
                        input int wpid, input logic ack, input logic dea, input int did);
        @(negedge clk);
        sw_wr_en = we; sw_wr_vid = VW'(wvid); sw_wr_state = 2'(wst);
        sw_wr_link = wlink; sw_wr_pid = PW'(wpid);
        gst_ack = ack; gst_deact = dea; gst_deact_id = VW'(did);
        #1 last_ack = int'(gst_ack_id);
        @(posedge clk); #1;
        sw_wr_en = 1'b0; gst_ack = 1'b0; gst_deact = 1'b0;
    endtask

    task automatic wr(input int v, input int s, input logic l, input int p);
        step(1'b1, v, s, l, p, 1'b0, 1'b0, 0);
    endtask

    task automatic t_reset;
        check("R1 state", int'(rd_state), 0);
        check("R1 vid", int'(rd_vid), 0);
        check("R1 empty", int'(slot_empty), 1);
        check("R1 vld", int'(phys_deact_vld), 0);
        check("R1 err", int'(wr_err), 0);
    endtask

    task automatic t_write_ack;
        wr(37, 1, 1'b0, 5);
        check("R2 vid", int'(rd_vid), 37);
        check("R2 state", int'(rd_state), 1);
        check("R2 pid", int'(rd_pid), 5);
        check("R2 empty", int'(slot_empty), 0);
        step(1'b0, 0, 0, 1'b0, 0, 1'b1, 1'b0, 0);
        check("R3 ack id", last_ack, 37);
        check("R3 state", int'(rd_state), 2);
        step(1'b0, 0, 0, 1'b0, 0, 1'b1, 1'b0, 0);
        check("R5 ack active-only", last_ack, 1023);
        check("R5 state kept", int'(rd_state), 2);
    endtask

    task automatic t_deact;
        step(1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b1, 38);
        check("R7 mismatch ignored", int'(rd_state), 2);
        step(1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b1, 37);
        check("R7 deact", int'(rd_state), 0);
        check("R8 unlinked no req", int'(phys_deact_vld), 0);
        check("R2 empty again", int'(slot_empty), 1);
        step(1'b0, 0, 0, 1'b0, 0, 1'b1, 1'b0, 0);
        check("R5 ack inactive", last_ack, 1023);
        check("R5 inactive kept", int'(rd_state), 0);
    endtask

    task automatic t_pend_hold;
        wr(21, 1, 1'b0, 0);
        for (int i = 0; i < 5; i++) step(1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b0, 0);
        step(1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b1, 21);
        check("R6 pending held", int'(rd_state), 1);
    endtask

    task automatic t_both;
        wr(50, 3, 1'b0, 0);
        step(1'b0, 0, 0, 1'b0, 0, 1'b1, 1'b0, 0);
        check("R4 ack id", last_ack, 50);
        check("R4 state", int'(rd_state), 2);
        wr(50, 3, 1'b0, 0);
        step(1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b1, 50);
        check("R7 both to pend", int'(rd_state), 1);
    endtask

    task automatic t_linked;
        wr(40, 1, 1'b1, 77);
        step(1'b0, 0, 0, 1'b0, 0, 1'b1, 1'b0, 0);
        check("R3 linked ack", int'(rd_state), 2);
        check("R8 no req yet", int'(phys_deact_vld), 0);
        step(1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b1, 40);
        check("R8 vld", int'(phys_deact_vld), 1);
        check("R8 pid", int'(phys_deact_pid), 77);
        check("R8 state", int'(rd_state), 0);
        step(1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b0, 0);
        check("R8 one cycle", int'(phys_deact_vld), 0);
    endtask

    task automatic t_reject;
        wr(40, 1, 1'b1, 77);
        wr(9, 3, 1'b1, 3);
        check("R9 err", int'(wr_err), 1);
        check("R9 vid kept", int'(rd_vid), 40);
        check("R9 state kept", int'(rd_state), 1);
        check("R9 pid kept", int'(rd_pid), 77);
        step(1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b0, 0);
        check("R9 err pulse", int'(wr_err), 0);
    endtask

    task automatic t_priority;
        // slot is linked pending vid 40: write + ack same cycle
        step(1'b1, 12, 1, 1'b1, 88, 1'b1, 1'b0, 0);
        check("R10 ack masked id", last_ack, 1023);
        check("R10 state from write", int'(rd_state), 1);
        check("R10 vid from write", int'(rd_vid), 12);
        step(1'b0, 0, 0, 1'b0, 0, 1'b1, 1'b0, 0);
        check("R10 setup active", int'(rd_state), 2);
        step(1'b1, 12, 2, 1'b1, 88, 1'b0, 1'b1, 12);
        check("R10 no req", int'(phys_deact_vld), 0);
        check("R10 still active", int'(rd_state), 2);
        // rejected write also masks the deactivate
        step(1'b1, 12, 3, 1'b1, 88, 1'b0, 1'b1, 12);
        check("R10 reject masks req", int'(phys_deact_vld), 0);
        check("R10 reject keeps active", int'(rd_state), 2);
    endtask

    initial begin : watchdog
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 t_reset();
        rst_n = 1'b1;
        #1 t_reset();
        t_write_ack();
        t_deact();
        t_pend_hold();
        t_both();
        t_linked();
        t_reject();
        t_priority();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule